// File: doc/BRIEF.md
# Selectable Ring / Twisted-Ring Counter

This block is a shift-register counter whose register length is set by a parameter. One mode input chooses the feedback path. In ring mode the top stage wraps back into stage 0 unchanged, so a single high bit circulates and the counter has modulus STAGES. In twisted mode the complement of the top stage enters stage 0, so a run of ones grows and then drains, and the counter has modulus 2·STAGES. A ring state is one-hot, so a consumer can use each output bit directly as a phase strobe. A twisted state needs two-bit decoding downstream to name each count.

A small controller tracks which feedback style is running. It has two states: `PH_RING` and `PH_TWIST`. On every rising edge it takes one of two transitions. `ACT_LOAD` is taken when `init_i` is high, or when `mode_i` differs from the running phase. It loads the starting pattern for the mode on `mode_i`, which is stage 0 high for ring mode and all zeros for twisted mode. `ACT_STEP` is taken otherwise and advances the register one position with the feedback of the running phase.

A combinational flag reports when the held pattern is not a legal state of the mode currently presented on `mode_i`. This happens during the one cycle after the mode input changes and before the reload takes effect.

Top module: `loop_counter`

## Requirements
- R1: While `rst_n` is low, `count_o` is held at the ring starting pattern (bit 0 high, all other bits low) and the phase is `PH_RING`.
- R2: A rising edge with `init_i` high and `mode_i` = 0 loads `count_o` with bit 0 high and all other bits low.
- R3: A rising edge with `init_i` high and `mode_i` = 1 loads `count_o` with all zeros.
- R4: In ring mode each rising edge moves bit k to bit k+1, and bit STAGES-1 to bit 0. The sequence repeats every STAGES edges.
- R5: In twisted mode each rising edge moves bit k to bit k+1 and loads bit 0 with the inverse of bit STAGES-1. For STAGES = 4, starting from 0000, the bus values (bit 3 leftmost) are 0001, 0011, 0111, 1111, 1110, 1100, 1000, then 0000.
- R6: `init_i` has priority over counting. While it stays high, `count_o` stays at the starting pattern of the selected mode.
- R7: When `mode_i` differs from the running phase and `init_i` is low, the next edge loads the starting pattern of the new mode instead of stepping. Counting with the new feedback begins on the edge after that.
- R8: `illegal_o` is combinational from `count_o` and `mode_i`. With `mode_i` = 0 it is high unless exactly one bit of `count_o` is 1. With `mode_i` = 1 it is high when more than one adjacent bit pair of `count_o` differs.
- R9: While the phase is `PH_RING`, `count_o` holds exactly one 1. While the phase is `PH_TWIST` and `mode_i` = 1, `illegal_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous load of the starting pattern for `mode_i` |
| mode_i | input | 1 | Feedback select: 0 ring, 1 twisted |
| count_o | output | STAGES | Register state, stage 0 at bit 0 |
| illegal_o | output | 1 | Held pattern is not a legal state of the mode on `mode_i` |

## Verification
The ring sequence is run for two full periods from its seed, so the test can tell a rotation that wraps from one that drops the top bit. The twisted sequence is run past its 2·STAGES period, so the test can tell a complemented feedback from a plain one and catch a wrong modulus. The mode is switched while the register holds a pattern that is legal only in the old mode. This pattern sets the illegal flag and shows that the next edge reloads rather than steps. Holding `init_i` high over several edges mid-sequence separates load priority from counting.

// File: rtl/loop_counter_pkg.sv
`timescale 1ns/1ps
package loop_counter_pkg;
    typedef enum logic { PH_RING = 1'b0, PH_TWIST = 1'b1 } phase_e;
    typedef enum logic { ACT_STEP = 1'b0, ACT_LOAD = 1'b1 } act_e;
endpackage

// File: rtl/loop_counter_step.sv
`timescale 1ns/1ps
// Next-state function: one shift position with selectable feedback.
module loop_counter_step #(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] cur,
    input  logic              twist,
    output logic [STAGES-1:0] nxt
);
    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_shift
            assign nxt[k] = cur[k-1];
        end
    endgenerate
    assign nxt[0] = twist ? ~cur[STAGES-1] : cur[STAGES-1];
endmodule

// File: rtl/loop_counter_legal.sv
`timescale 1ns/1ps
// Pattern legality: ring needs exactly one 1, twisted needs at most one
// boundary between adjacent differing stages.
module loop_counter_legal #(
    parameter int STAGES = 4
) (
    input  logic [STAGES-1:0] pattern,
    input  logic              twist,
    output logic              legal
);
    localparam int CW = $clog2(STAGES + 1);

    logic [CW-1:0] ones;
    logic [CW-1:0] edges;

    always_comb begin
        ones  = '0;
        edges = '0;
        for (int k = 0; k < STAGES; k++) begin
            ones = ones + CW'(pattern[k]);
        end
        for (int k = 0; k < STAGES - 1; k++) begin
            edges = edges + CW'(pattern[k] ^ pattern[k+1]);
        end
        legal = twist ? (edges <= CW'(1)) : (ones == CW'(1));
    end
endmodule

// File: rtl/loop_counter.sv
`timescale 1ns/1ps
module loop_counter #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              mode_i,
    output logic [STAGES-1:0] count_o,
    output logic              illegal_o
);
    import loop_counter_pkg::*;

    localparam logic [STAGES-1:0] RING_SEED  = STAGES'(1);
    localparam logic [STAGES-1:0] TWIST_SEED = '0;

    phase_e            phase_q, phase_d;
    act_e              act;
    logic [STAGES-1:0] cnt_q, cnt_d, stepped, seed;
    logic              twist_run;
    logic              fits;

    assign phase_d   = phase_e'(mode_i);
    assign twist_run = (phase_q == PH_TWIST);
    assign act       = (init_i || (phase_d != phase_q)) ? ACT_LOAD : ACT_STEP;

    always_comb begin
        unique case (phase_d)
            PH_RING:  seed = RING_SEED;
            PH_TWIST: seed = TWIST_SEED;
            default:  seed = RING_SEED;
        endcase
    end

    always_comb begin
        unique case (act)
            ACT_LOAD: cnt_d = seed;
            ACT_STEP: cnt_d = stepped;
            default:  cnt_d = seed;
        endcase
    end

    loop_counter_step #(.STAGES(STAGES)) u_step (
        .cur   (cnt_q),
        .twist (twist_run),
        .nxt   (stepped)
    );

    loop_counter_legal #(.STAGES(STAGES)) u_legal (
        .pattern (cnt_q),
        .twist   (mode_i),
        .legal   (fits)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RING;
            cnt_q   <= RING_SEED;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        count_o   = cnt_q;
        illegal_o = !fits;
    end
endmodule

// File: rtl/loop_counter_sva.sv
`timescale 1ns/1ps
module loop_counter_sva #(
    parameter int STAGES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              mode_i,
    input logic [STAGES-1:0] count_o,
    input logic              illegal_o,
    input logic              run_twist
);
    assert_init_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && !mode_i) |=> (count_o == STAGES'(1)));

    assert_init_twist_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && mode_i) |=> (count_o == '0));

    assert_ring_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !mode_i && !run_twist) |=>
        (count_o == {$past(count_o[STAGES-2:0]), $past(count_o[STAGES-1])}));

    assert_twist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && mode_i && run_twist) |=>
        (count_o == {$past(count_o[STAGES-2:0]), ~$past(count_o[STAGES-1])}));

    assert_switch_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && (mode_i != run_twist)) |=>
        (count_o == ($past(mode_i) ? STAGES'(0) : STAGES'(1))));

    assert_ring_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && ($countones(count_o) != 1)) |-> illegal_o);

    assert_ring_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_twist |-> ($countones(count_o) == 1));

    assert_twist_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_twist && mode_i) |-> !illegal_o);
endmodule

bind loop_counter loop_counter_sva #(.STAGES(STAGES)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (init_i),
    .mode_i    (mode_i),
    .count_o   (count_o),
    .illegal_o (illegal_o),
    .run_twist (twist_run)
);

// File: tb/tb_loop_counter.sv
`timescale 1ns/1ps
module tb_loop_counter;
    localparam int N = 4;
    localparam logic [N-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [N-1:0] count_o;
    logic         illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    loop_counter #(.STAGES(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .mode_i    (mode_i),
        .count_o   (count_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [N-1:0] ring_exp(input int k);
        return N'(1) << (k % N);
    endfunction

    function automatic logic [N-1:0] twist_exp(input int k);
        int m;
        m = k % (2 * N);
        if (m <= N) return N'((1 << m) - 1);
        return MASK - N'((1 << (m - N)) - 1);
    endfunction

    task automatic test_reset();
        rst_n = 1'b0; init_i = 1'b0; mode_i = 1'b0;
        tick(); tick();
        check("R1 reset seed", 32'(count_o), 32'(N'(1)));
        check("R1 reset flag", 32'(illegal_o), 32'd0);
        rst_n = 1'b1;
        tick();
        check("R1/R4 first step after reset", 32'(count_o), 32'(ring_exp(1)));
    endtask

    task automatic test_ring_cycle();
        init_i = 1'b1; mode_i = 1'b0;
        tick();
        check("R2 ring init", 32'(count_o), 32'(N'(1)));
        init_i = 1'b0;
        for (int k = 1; k <= 2 * N; k++) begin
            tick();
            check("R4 ring step", 32'(count_o), 32'(ring_exp(k)));
            check("R9 ring flag low", 32'(illegal_o), 32'd0);
        end
    endtask

    task automatic test_twist_cycle();
        init_i = 1'b1; mode_i = 1'b1;
        tick();
        check("R3 twist init", 32'(count_o), 32'd0);
        init_i = 1'b0;
        for (int k = 1; k <= 2 * N + 1; k++) begin
            tick();
            check("R5 twist step", 32'(count_o), 32'(twist_exp(k)));
            check("R9 twist flag low", 32'(illegal_o), 32'd0);
        end
    endtask

    task automatic test_init_priority();
        init_i = 1'b1; mode_i = 1'b1;
        tick();
        init_i = 1'b0;
        tick(); tick(); tick();
        check("R5 twist before hold", 32'(count_o), 32'(twist_exp(3)));
        init_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R6 init holds twist seed", 32'(count_o), 32'd0);
        end
        mode_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R6 init holds ring seed", 32'(count_o), 32'(N'(1)));
        end
        init_i = 1'b0;
        tick();
        check("R6 counting resumes", 32'(count_o), 32'(ring_exp(1)));
    endtask

    task automatic test_mode_switch();
        init_i = 1'b1; mode_i = 1'b0;
        tick();
        init_i = 1'b0;
        tick(); tick();
        check("R4 ring at stage 2", 32'(count_o), 32'(ring_exp(2)));
        mode_i = 1'b1;
        #1;
        check("R8 ring pattern under twist flagged", 32'(illegal_o), 32'd1);
        tick();
        check("R7 switch to twist reloads", 32'(count_o), 32'd0);
        check("R8 flag clears after reload", 32'(illegal_o), 32'd0);
        tick();
        check("R7 twist counts after reload", 32'(count_o), 32'(twist_exp(1)));
        tick();
        check("R7 twist second step", 32'(count_o), 32'(twist_exp(2)));
        mode_i = 1'b0;
        #1;
        check("R8 two ones under ring flagged", 32'(illegal_o), 32'd1);
        tick();
        check("R7 switch to ring reloads", 32'(count_o), 32'(N'(1)));
        tick();
        check("R7 ring counts after reload", 32'(count_o), 32'(ring_exp(1)));
    endtask

    task automatic test_illegal_zero();
        init_i = 1'b1; mode_i = 1'b1;
        tick();
        init_i = 1'b0;
        mode_i = 1'b0;
        #1;
        check("R8 zero pattern under ring flagged", 32'(illegal_o), 32'd1);
        tick();
        check("R8 reload clears flag", 32'(illegal_o), 32'd0);
        check("R7 reload to ring seed", 32'(count_o), 32'(N'(1)));
    endtask

    initial begin
        test_reset();
        test_ring_cycle();
        test_twist_cycle();
        test_init_priority();
        test_mode_switch();
        test_illegal_zero();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule